// File: doc/BRIEF.md
# Multi-Mode Capture/Compare Channel

This block is one compare/capture channel that sits beside a shared free-running counter. The counter value arrives as an input every cycle. An 8-bit mode byte picks one of six behaviours: capture of the counter on an input edge, a software timer match, a toggle-on-match output, a frequency output that steps its own compare value, a PWM whose cycle length is 8 to 11 bits, or a full-width PWM. A small PWM-configuration word is shared by every channel. It selects the short-PWM cycle length, enables an overflow interrupt, and chooses which register the access port reaches.

Software reads and writes the channel through a plain register port. That port is a write strobe with write data and a combinational read-data output. It has no handshake and never stalls, so there is no back-pressure anywhere on the block. In the 9-to-11-bit PWM modes, writes can be steered into an auto-reload shadow register. The shadow is copied into the active compare register at each cycle boundary, so a duty-cycle change never takes effect in the middle of a period. A single clear strobe drops both event flags.

Top module: `ccx_channel`

## Requirements
- R1: After reset the output pin, the event flag, the interrupt request and the read data are all 0.
- R2: The access port reaches the auto-reload register only when pwm_cfg_i[3] is 1, the mode is short PWM (mode_i[7]=0, mode_i[2:1]=01) and the length field pwm_cfg_i[1:0] is not 00. In every other case it reaches the compare/capture register. Read data is combinational, and a write takes effect at the next edge.
- R3: In capture mode (mode_i[3:1]=000, with mode_i[5] enabling rising edges and mode_i[4] enabling falling edges), a qualifying edge on cap_pin_i latches cnt_i into the compare/capture register and sets the flag. Both happen on the third rising clock edge after the pin changes. Edges that are not enabled change nothing.
- R4: In timer mode (mode_i[3:1]=100), equality of cnt_i with the full 16-bit compare register sets the flag. The output pin holds its value.
- R5: In toggle mode (mode_i[3:1]=110), a full 16-bit match inverts the output pin, and also sets the flag when mode_i[3] is 1.
- R6: In frequency mode (mode_i[3:1]=011), a match of the low byte of cnt_i with the low byte of the compare register inverts the pin. The same match adds the compare high byte to the compare low byte.
- R7: In PWM modes the pin goes high on the next edge when the low W bits of cnt_i are at or above the low W bits of the compare register, and low otherwise. W is 8 plus pwm_cfg_i[1:0] in short PWM, and 16 when mode_i[7] is 1. A low-W-bit match sets the flag when mode_i[3] is 1.
- R8: With mode_i[6]=0 the comparator is off. No match sets the flag, the pin never toggles in toggle or frequency mode, and the pin is 0 in every PWM mode.
- R9: In short PWM with a length other than 8 bits, a cycle boundary (low W bits of cnt_i all zero) copies the auto-reload register into the compare register, unless a write hits the compare register in the same cycle.
- R10: In short PWM a cycle boundary sets the overflow flag. That flag raises irq_o when pwm_cfg_i[2] is 1.
- R11: irq_o is high when the event flag is set and mode_i[0] is 1, or when the overflow flag is set and its enable is on. clr_i clears both flags, and a new set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 8 | Mode-control byte |
| pwm_cfg_i | input | 4 | Shared PWM config: [1:0] length, [2] overflow irq enable, [3] reload-register select |
| cnt_i | input | 16 | Shared counter value |
| cap_pin_i | input | 1 | External capture input (asynchronous) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Selected register read data |
| clr_i | input | 1 | Flag clear strobe |
| out_pin_o | output | 1 | Channel output pin |
| flag_o | output | 1 | Channel event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the channel with its default parameters: a 16-bit counter, an 8-bit base PWM width, a 2-bit length field and two synchroniser stages. Because the bench drives the counter directly instead of letting it run, the 9-bit boundary at 0x0200, the 8-bit wrap and the 16-bit midpoint can each be hit in a single cycle. With two synchroniser stages, the capture latency is a fixed three edges that the scoreboard can predict.

// File: rtl/ccx_pkg.sv
package ccx_pkg;
  typedef enum logic [2:0] {
    CM_IDLE,
    CM_CAPTURE,
    CM_TIMER,
    CM_HSO,
    CM_FREQ,
    CM_PWMN,
    CM_PWM16
  } ccx_mode_e;

  typedef struct packed {
    ccx_mode_e mode;
    logic      cmp_en;
    logic      rise_en;
    logic      fall_en;
    logic      match_en;
    logic      irq_en;
  } ccx_ctl_t;
endpackage

// File: rtl/ccx_decode.sv
module ccx_decode
  import ccx_pkg::*;
(
  input  logic [7:0] mode_i,
  output ccx_ctl_t   ctl_o
);
  always_comb begin
    ctl_o.cmp_en   = mode_i[6];
    ctl_o.rise_en  = mode_i[5];
    ctl_o.fall_en  = mode_i[4];
    ctl_o.match_en = mode_i[3];
    ctl_o.irq_en   = mode_i[0];
    if (mode_i[3:1] == 3'b000 && (mode_i[5] || mode_i[4]))
      ctl_o.mode = CM_CAPTURE;
    else if (mode_i[3:1] == 3'b100)
      ctl_o.mode = CM_TIMER;
    else if (mode_i[3:1] == 3'b110)
      ctl_o.mode = CM_HSO;
    else if (mode_i[3:1] == 3'b011)
      ctl_o.mode = CM_FREQ;
    else if (mode_i[2:1] == 2'b01)
      ctl_o.mode = mode_i[7] ? CM_PWM16 : CM_PWMN;
    else
      ctl_o.mode = CM_IDLE;
  end
endmodule

// File: rtl/ccx_sync.sv
module ccx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh[0] <= 1'b0;
        else        sh[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh[g] <= 1'b0;
        else        sh[g] <= sh[g-1];
    end
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
  assign fall_o = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/ccx_compare.sv
module ccx_compare #(
  parameter int CNT_W  = 16,
  parameter int BASE_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             wide_i,
  output logic             eq_o,
  output logic             ge_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] cnt_lo;
  logic [CNT_W-1:0] cmp_lo;

  always_comb begin
    for (int b = 0; b < CNT_W; b++)
      mask[b] = wide_i || (b < BASE_W + int'(len_i));
  end

  assign cnt_lo = cnt_i & mask;
  assign cmp_lo = cmp_i & mask;
  assign eq_o   = (cnt_lo == cmp_lo);
  assign ge_o   = (cnt_lo >= cmp_lo);
  assign wrap_o = (cnt_lo == '0);
endmodule

// File: rtl/ccx_channel.sv
module ccx_channel
  import ccx_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BASE_W      = 8,
  parameter int LEN_W       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CFG_W      = LEN_W + 2,
  localparam int HALF_W     = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       mode_i,
  input  logic [CFG_W-1:0] pwm_cfg_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cap_pin_i,
  input  logic             reg_wr_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  input  logic             clr_i,
  output logic             out_pin_o,
  output logic             flag_o,
  output logic             irq_o
);
  ccx_ctl_t ctl;
  logic [LEN_W-1:0] len;
  logic ovf_ie, arl_sel;
  logic cap_rise, cap_fall;
  logic cmp_eq, cmp_ge, cnt_wrap;
  logic [CNT_W-1:0] cmp_q, cmp_n, arl_q, arl_n;
  logic pin_q, pin_n, flag_q, ovf_q;
  logic set_ev, set_ovf;
  logic is_pwm, is_short, use_arl, reload, tmr_hit, frq_hit;

  assign len     = pwm_cfg_i[LEN_W-1:0];
  assign ovf_ie  = pwm_cfg_i[LEN_W];
  assign arl_sel = pwm_cfg_i[LEN_W+1];

  ccx_decode u_dec (.mode_i(mode_i), .ctl_o(ctl));

  ccx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cap_pin_i),
    .rise_o(cap_rise), .fall_o(cap_fall)
  );

  ccx_compare #(.CNT_W(CNT_W), .BASE_W(BASE_W), .LEN_W(LEN_W)) u_cmp (
    .cnt_i(cnt_i), .cmp_i(cmp_q), .len_i(len),
    .wide_i(ctl.mode == CM_PWM16),
    .eq_o(cmp_eq), .ge_o(cmp_ge), .wrap_o(cnt_wrap)
  );

  assign is_short = (ctl.mode == CM_PWMN);
  assign is_pwm   = is_short || (ctl.mode == CM_PWM16);
  assign use_arl  = arl_sel && is_short && (len != '0);
  assign reload   = is_short && (len != '0) && cnt_wrap;
  assign tmr_hit  = ctl.cmp_en && (cnt_i == cmp_q);
  assign frq_hit  = ctl.cmp_en && (cnt_i[HALF_W-1:0] == cmp_q[HALF_W-1:0]);

  always_comb begin
    cmp_n   = cmp_q;
    arl_n   = arl_q;
    pin_n   = pin_q;
    set_ev  = 1'b0;
    set_ovf = 1'b0;
    unique case (ctl.mode)
      CM_CAPTURE: begin
        if ((cap_rise && ctl.rise_en) || (cap_fall && ctl.fall_en)) begin
          cmp_n  = cnt_i;
          set_ev = 1'b1;
        end
      end
      CM_TIMER: begin
        set_ev = tmr_hit && ctl.match_en;
      end
      CM_HSO: begin
        if (tmr_hit) begin
          pin_n  = ~pin_q;
          set_ev = ctl.match_en;
        end
      end
      CM_FREQ: begin
        if (frq_hit) begin
          pin_n = ~pin_q;
          cmp_n[HALF_W-1:0] = cmp_q[HALF_W-1:0] + cmp_q[CNT_W-1:HALF_W];
        end
      end
      CM_PWMN, CM_PWM16: begin
        pin_n   = ctl.cmp_en && cmp_ge;
        set_ev  = ctl.cmp_en && cmp_eq && ctl.match_en;
        set_ovf = is_short && cnt_wrap;
        if (reload) cmp_n = arl_q;
      end
      default: ;
    endcase
    if (reg_wr_i) begin
      if (use_arl) arl_n = reg_wdata_i;
      else         cmp_n = reg_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      arl_q  <= '0;
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      cmp_q  <= cmp_n;
      arl_q  <= arl_n;
      pin_q  <= pin_n;
      flag_q <= set_ev  || (flag_q && !clr_i);
      ovf_q  <= set_ovf || (ovf_q && !clr_i);
    end
  end

  assign reg_rdata_o = use_arl ? arl_q : cmp_q;
  assign out_pin_o   = pin_q;
  assign flag_o      = flag_q;
  assign irq_o       = (flag_q && ctl.irq_en) || (ovf_q && ovf_ie);

  assert_pwm_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pwm && !mode_i[6]) |=> !out_pin_o);

  assert_no_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl.mode == CM_HSO || ctl.mode == CM_FREQ) && !mode_i[6]) |=> $stable(out_pin_o));

  assert_timer_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.mode == CM_TIMER) |=> $stable(out_pin_o));

  assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !reg_wr_i) |=> (cmp_q == $past(arl_q)));

  assert_capture_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.mode == CM_CAPTURE && ctl.rise_en && cap_rise) |=> (flag_o && cmp_q == $past(cnt_i)));

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_ev) |=> !flag_o);
endmodule

// File: tb/sim_ccx_channel.sv
module sim_ccx_channel;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mode = '0;
  logic [3:0]  cfg = '0;
  logic [15:0] cnt = '0;
  logic        pin = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        clr = 1'b0;
  logic        opin, flag, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int          kind;
    logic [15:0] val;
    string       req;
  } exp_t;
  exp_t q[$];

  always #(CLK_P/2) clk = ~clk;

  ccx_channel u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .pwm_cfg_i(cfg), .cnt_i(cnt),
    .cap_pin_i(pin), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .clr_i(clr), .out_pin_o(opin), .flag_o(flag), .irq_o(irq)
  );

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      logic [15:0] act;
      e = q.pop_front();
      case (e.kind)
        0: act = {15'b0, opin};
        1: act = {15'b0, flag};
        2: act = {15'b0, irq};
        default: act = rdata;
      endcase
      checks++;
      if (act !== e.val) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", e.req, e.kind, act, e.val);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push(int kind, logic [15:0] v, string req);
    exp_t e;
    e.kind = kind; e.val = v; e.req = req;
    q.push_back(e);
  endtask

  task automatic flush();
    @(negedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; mode = '0; cfg = '0; cnt = '0; pin = 1'b0;
    wr = 1'b0; wdata = '0; clr = 1'b0;
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic write_reg(logic [15:0] v);
    wr = 1'b1; wdata = v; step(); wr = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    push(0, 0, "R1"); push(1, 0, "R1"); push(2, 0, "R1"); push(3, 0, "R1");
    flush();

    // R4 software timer: full match sets flag, pin held
    write_reg(16'h0050);
    push(3, 16'h0050, "R2"); flush();
    mode = 8'h49; cnt = 16'h004F; step();
    push(1, 0, "R4"); flush();
    cnt = 16'h0050; step();
    push(1, 1, "R4"); push(2, 1, "R11"); push(0, 0, "R4"); flush();
    clr = 1'b1; cnt = 16'h0051; step(); clr = 1'b0;
    push(1, 0, "R11"); flush();
    // R8 comparator off: no flag
    mode = 8'h09; cnt = 16'h0050; step();
    push(1, 0, "R8"); flush();

    // R5 toggle output
    do_reset();
    write_reg(16'h0050);
    mode = 8'h4C; cnt = 16'h0050; step();
    push(0, 1, "R5"); push(1, 1, "R5"); flush();
    cnt = 16'h0051; step();
    push(0, 1, "R5"); flush();
    cnt = 16'h0050; step();
    push(0, 0, "R5"); flush();
    mode = 8'h0C; cnt = 16'h0050; step();
    push(0, 0, "R8"); flush();

    // R6 frequency output
    do_reset();
    write_reg(16'h0310);
    mode = 8'h46; cnt = 16'h0010; step();
    push(0, 1, "R6"); push(3, 16'h0313, "R6"); flush();
    cnt = 16'h0013; step();
    push(0, 0, "R6"); push(3, 16'h0316, "R6"); flush();
    mode = 8'h06; cnt = 16'h0016; step();
    push(0, 0, "R8"); push(3, 16'h0316, "R8"); flush();

    // R7 8-bit PWM, match flag, irq gating, R10 overflow
    do_reset();
    write_reg(16'h0080);
    mode = 8'h4A; cnt = 16'h017F; step();
    push(0, 0, "R7"); flush();
    cnt = 16'h0180; step();
    push(0, 1, "R7"); push(1, 1, "R7"); push(2, 0, "R11"); flush();
    cnt = 16'h01FF; step();
    push(0, 1, "R7"); flush();
    cfg = 4'b0100; cnt = 16'h0200; step();
    push(0, 0, "R7"); push(2, 1, "R10"); flush();
    mode = 8'h02; cnt = 16'h01F0; cfg = 4'b0000; step();
    push(0, 0, "R8"); flush();

    // R2 select ignored in 8-bit PWM
    do_reset();
    mode = 8'h42; cfg = 4'b1000; cnt = 16'h0010;
    write_reg(16'h0077);
    push(3, 16'h0077, "R2"); flush();
    cfg = 4'b1001;
    push(3, 16'h0000, "R2"); flush();

    // R9 9-bit PWM with auto-reload
    do_reset();
    mode = 8'h42; cfg = 4'b1001; cnt = 16'h0005;
    write_reg(16'h0100);
    push(0, 1, "R9"); push(3, 16'h0100, "R2"); flush();
    cfg = 4'b0001;
    push(3, 16'h0000, "R9"); flush();
    cnt = 16'h0200; step();
    push(0, 1, "R9"); push(3, 16'h0100, "R9"); flush();
    cnt = 16'h0201; step();
    push(0, 0, "R9"); flush();
    cnt = 16'h03FF; step();
    push(0, 1, "R7"); flush();

    // R7 16-bit PWM
    do_reset();
    write_reg(16'h8000);
    mode = 8'hC2; cnt = 16'h7FFF; step();
    push(0, 0, "R7"); flush();
    cnt = 16'h8000; step();
    push(0, 1, "R7"); flush();

    // R3 capture, rising only
    do_reset();
    mode = 8'h21; cnt = 16'h1234; pin = 1'b1; step(); step();
    push(1, 0, "R3"); flush();
    step();
    push(1, 1, "R3"); push(2, 1, "R11"); push(3, 16'h1234, "R3"); flush();
    clr = 1'b1; step(); clr = 1'b0;
    cnt = 16'h2222; pin = 1'b0; step(); step(); step(); step();
    push(1, 0, "R3"); push(3, 16'h1234, "R3"); flush();
    // falling only
    mode = 8'h11; pin = 1'b1; step(); step(); step(); step();
    push(1, 0, "R3"); flush();
    cnt = 16'h3333; pin = 1'b0; step(); step(); step();
    push(1, 1, "R3"); push(3, 16'h3333, "R3"); flush();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule